// File: doc/BRIEF.md
# Binary and Decimal Accumulator ALU

This block is the arithmetic and logic stage for the accumulator of a small 8-bit processor. Each operation takes the accumulator value, an 8-bit operand and the current status byte. It produces a new accumulator value and a new status byte. The supported operations are:

- binary add with carry;
- subtract, done as an add of the inverted operand with the carry;
- two-digit packed decimal add;
- bitwise AND, OR and XOR.

The carry/link flag and the overflow flag live inside the status byte. The other six status bits go through unchanged.

The operation itself is combinational. The result and the updated status are captured in output registers on a cycle when `en_i` is high. The caller can therefore feed the registered values back as the next accumulator and status. Operand fetch and instruction sequencing belong to the caller.

Top module: `acc_alu`

## Requirements
- R1: Binary add (op_i = 3) captures the low 8 bits of ac_i + operand_i + status_i[7] into res_o. Bit 8 of that 9-bit sum goes to status_o[7], the carry/link bit.
- R2: For both add forms (op_i = 3 and 4), status_o[6] is set only when the two adder inputs share a sign bit and the result sign differs from it; otherwise status_o[6] is cleared.
- R3: Complement add (op_i = 4) behaves exactly as binary add with operand_i replaced by ~operand_i, using the same carry-in status_i[7]. No separate borrow logic is involved.
- R4: Decimal add (op_i = 5) forms s = ac_i + operand_i + status_i[7]. It adds 6 to s when s[3:0] exceeds 9, then captures s modulo 0xA0 into res_o. res_o is therefore always below 0xA0.
- R5: Decimal add sets status_o[7] when the adjusted sum s exceeds 0x99 and clears it otherwise.
- R6: Decimal add leaves status_o[6] equal to status_i[6].
- R7: AND (op_i = 0), OR (op_i = 1) and XOR (op_i = 2) capture the bitwise result of ac_i and operand_i, and the status byte goes through unchanged.
- R8: status_o[5:0] always equals the status_i[5:0] presented on the capture cycle, whatever the operation.
- R9: Unused codes (op_i = 6 and 7) capture ac_i and status_i unchanged.
- R10: Outputs update one clock after a cycle with en_i high and hold while en_i is low. After reset both res_o and status_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Capture the result and status this cycle |
| op_i | input | 3 | Operation code (0 AND, 1 OR, 2 XOR, 3 ADD, 4 complement add, 5 decimal add, 6/7 pass) |
| ac_i | input | 8 | Accumulator value |
| operand_i | input | 8 | Second operand |
| status_i | input | 8 | Current status byte (bit 7 carry/link, bit 6 overflow) |
| res_o | output | 8 | Registered new accumulator |
| status_o | output | 8 | Registered new status byte |

## Verification
Random operands with random status bytes exercise every operation against a bench model. The random status bytes expose any leak of the carry into the logic operations and any disturbance of the untouched bits. Directed sign-boundary cases separate a correct overflow rule from one that looks only at the carry out:

- 0x7F + 0x01;
- 0x80 + 0x80;
- a complement add of equal values with the carry set and then clear.

Decimal corners decide whether the nibble adjust, the modulo-0xA0 wrap and the above-0x99 carry are each implemented as specified: 0x99 + 0x01, 0x09 + 0x09 + carry, and 0xFF + 0xFF + carry. Idle cycles with changing inputs check that the output registers hold.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned CY_BIT = 7;
  localparam int unsigned OV_BIT = 6;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'd0,
    OP_OR  = 3'd1,
    OP_XOR = 3'd2,
    OP_ADD = 3'd3,
    OP_CAD = 3'd4,
    OP_DAD = 3'd5
  } alu_op_e;
endpackage

// File: rtl/acc_bin_adder.sv
module acc_bin_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W:0] full;

  always_comb begin
    full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o  = full[W-1:0];
    cout_o = full[W];
    // same input signs, different result sign
    ovf_o  = (a_i[W-1] == b_i[W-1]) && (full[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/acc_dec_adder.sv
module acc_dec_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned SW = W + 2;
  localparam logic [SW-1:0] MODV = SW'(160);
  localparam logic [SW-1:0] TOPV = SW'(153);

  logic [SW-1:0] raw, adj, red;

  always_comb begin
    raw = SW'(a_i) + SW'(b_i) + SW'(cin_i);
    adj = (raw[3:0] > 4'd9) ? raw + SW'(6) : raw;
    cout_o = adj > TOPV;
    // adj < 4*0xA0, so three conditional subtractions reduce it
    red = adj;
    for (int k = 0; k < 3; k++) begin
      if (red >= MODV) red = red - MODV;
    end
    sum_o = red[W-1:0];
  end
endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit #(
  parameter int unsigned W = 8
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i | b_i;
      default: y_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] ac_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] status_o
);
  logic              cin;
  logic              is_cad;
  logic [DATA_W-1:0] add_b, add_sum, dec_sum, log_y;
  logic              add_cy, add_ov, dec_cy;
  logic [DATA_W-1:0] res_d, st_d;
  logic [DATA_W-1:0] res_q, st_q;

  assign cin    = status_i[CY_BIT];
  assign is_cad = (op_i == OP_CAD);
  assign add_b  = is_cad ? ~operand_i : operand_i;

  acc_bin_adder #(.W(DATA_W)) u_bin (
    .a_i(ac_i), .b_i(add_b), .cin_i(cin),
    .sum_o(add_sum), .cout_o(add_cy), .ovf_o(add_ov)
  );

  acc_dec_adder #(.W(DATA_W)) u_dec (
    .a_i(ac_i), .b_i(operand_i), .cin_i(cin),
    .sum_o(dec_sum), .cout_o(dec_cy)
  );

  acc_logic_unit #(.W(DATA_W)) u_log (
    .sel_i(op_i[1:0]), .a_i(ac_i), .b_i(operand_i), .y_o(log_y)
  );

  always_comb begin
    res_d = ac_i;
    st_d  = status_i;
    case (op_i)
      OP_AND, OP_OR, OP_XOR: res_d = log_y;
      OP_ADD, OP_CAD: begin
        res_d          = add_sum;
        st_d[CY_BIT]   = add_cy;
        st_d[OV_BIT]   = add_ov;
      end
      OP_DAD: begin
        res_d        = dec_sum;
        st_d[CY_BIT] = dec_cy;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      st_q  <= '0;
    end else if (en_i) begin
      res_q <= res_d;
      st_q  <= st_d;
    end
  end

  assign res_o    = res_q;
  assign status_o = st_q;

  assert_logic_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i <= 3'd2) |=> status_o == $past(status_i))
    else $error("R7 logic op changed status");

  assert_dec_ov_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 3'd5) |=> status_o[OV_BIT] == $past(status_i[OV_BIT]))
    else $error("R6 decimal add touched overflow");

  assert_dec_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 3'd5) |=> res_o < 8'hA0)
    else $error("R4 decimal result out of range");

  assert_low_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> status_o[5:0] == $past(status_i[5:0]))
    else $error("R8 low status bits changed");

  assert_unused_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i >= 3'd6) |=> (res_o == $past(ac_i) && status_o == $past(status_i)))
    else $error("R9 unused op not passed through");

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(res_o) && $stable(status_o)))
    else $error("R10 outputs moved without enable");

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (op_i == 3'd3 || op_i == 3'd4) && (ac_i[7] != add_b[7]))
      |=> !status_o[OV_BIT])
    else $error("R2 overflow on mixed signs");
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] ac_i = '0, operand_i = '0, status_i = '0;
  logic [7:0] res_o, status_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk_i = ~clk_i;

  acc_alu dut (.*);

  function automatic void model(input logic [2:0] op, input logic [7:0] a, b, st,
                                output logic [7:0] r, output logic [7:0] so);
    int t; logic [7:0] bb; logic c;
    c = st[7]; so = st; r = a;
    case (op)
      3'd0: r = a & b;
      3'd1: r = a | b;
      3'd2: r = a ^ b;
      3'd3, 3'd4: begin
        bb = (op == 3'd4) ? ~b : b;
        t = int'(a) + int'(bb) + int'(c);
        r = t[7:0];
        so[7] = t[8];
        so[6] = (a[7] == bb[7]) && (r[7] != a[7]);
      end
      3'd5: begin
        t = int'(a) + int'(b) + int'(c);
        if ((t % 16) > 9) t = t + 6;
        so[7] = (t > 153);
        t = t % 160;
        r = t[7:0];
      end
      default: ;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1, 3'd2: return "R7";
      3'd3: return "R1/R2";
      3'd4: return "R3/R2";
      3'd5: return "R4/R5/R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act_r, exp_r, act_s, exp_s);
    n_tests++;
    if (act_r !== exp_r || act_s !== exp_s) begin
      n_fail++;
      $display("FAIL %s: res=%h st=%h expected res=%h st=%h", req, act_r, act_s, exp_r, exp_s);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [7:0] a, b, st);
    logic [7:0] er, es;
    model(op, a, b, st, er, es);
    op_i = op; ac_i = a; operand_i = b; status_i = st; en_i = 1'b1;
    @(negedge clk_i);
    en_i = 1'b0;
    check(req_of(op), res_o, er, status_o, es);
    // R8: low status bits follow the input
    n_tests++;
    if (status_o[5:0] !== st[5:0]) begin
      n_fail++;
      $display("FAIL R8: low=%h expected %h", status_o[5:0], st[5:0]);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] hr, hs;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R10 reset", res_o, 8'h00, status_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 carry out, R2 overflow corners
    run(3'd3, 8'hFF, 8'h00, 8'h80);
    run(3'd3, 8'h7F, 8'h01, 8'h00);
    run(3'd3, 8'h80, 8'h80, 8'h00);
    run(3'd3, 8'h40, 8'hC0, 8'h7F);
    // R3 complement add with and without carry
    run(3'd4, 8'h55, 8'h55, 8'h80);
    run(3'd4, 8'h55, 8'h55, 8'h00);
    run(3'd4, 8'h80, 8'h01, 8'h80);
    // R4/R5/R6 decimal corners
    run(3'd5, 8'h99, 8'h01, 8'h40);
    run(3'd5, 8'h09, 8'h09, 8'h80);
    run(3'd5, 8'hFF, 8'hFF, 8'hC0);
    run(3'd5, 8'h45, 8'h54, 8'h00);
    // R7 logic ops keep flags
    run(3'd0, 8'hF0, 8'h3C, 8'hC5);
    run(3'd1, 8'hF0, 8'h0F, 8'h80);
    run(3'd2, 8'hAA, 8'hFF, 8'h40);
    // R9 unused codes
    run(3'd6, 8'h12, 8'h34, 8'hAB);
    run(3'd7, 8'hFE, 8'h01, 8'h5A);

    // R10 hold while en_i low
    hr = res_o; hs = status_o;
    op_i = 3'd3; ac_i = 8'h11; operand_i = 8'h22; status_i = 8'hFF;
    repeat (3) @(negedge clk_i);
    check("R10 hold", res_o, hr, status_o, hs);

    for (int i = 0; i < 2000; i++) begin
      run(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule